// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Status-Word Flags

This block is the arithmetic core of a small 8-bit controller datapath. Each cycle it takes an operation select, the live accumulator, a second operand and the B register. On the next clock edge it registers the result bytes and updates the carry, auxiliary-carry and overflow flags of an 8-bit status word. Five operations are supported: add, add with carry, subtract with borrow, multiply and divide.

The status word can also be loaded as a whole through a write port. When a write and an arithmetic operation fall in the same cycle, the operation decides the flags it owns and the write decides the rest. The parity bit is never stored. It always shows the parity of the accumulator currently presented at the input.

Two status bits choose one of four working-register banks. The block turns that choice into a base address for working-register accesses.

Top module: `alu8_status_unit`

## Requirements
- R1: After reset `status_byte[7:1]`, `acc_res`, `b_res` and `bank_base` are all zero.
- R2: With `op_sel`=3'd1, `acc_res` becomes (acc_in+opnd_in) mod 256 at the next edge. In the same edge, status bit 7 (carry) takes the carry out of bit 7, bit 6 (auxiliary carry) takes the carry out of bit 3, and bit 2 (overflow) is set when two operands of equal sign give a result of the other sign. `b_res` holds its value.
- R3: With `op_sel`=3'd2, the stored carry (status bit 7) is added as a carry-in, and the flags follow the rules of R2.
- R4: With `op_sel`=3'd3, `acc_res` becomes acc_in-opnd_in-carry mod 256. Carry is set on a borrow out of bit 7. Auxiliary carry is set on a borrow into bit 3 from bit 4. Overflow is set when operands of differing sign give a result whose sign differs from acc_in. `b_res` holds.
- R5: With `op_sel`=3'd4, the product acc_in*breg_in goes out as low byte on `acc_res` and high byte on `b_res`. Overflow is set when the product exceeds 255, and carry is cleared.
- R6: With `op_sel`=3'd5 and breg_in nonzero, `acc_res` is the quotient and `b_res` the remainder of acc_in/breg_in. Carry and overflow are cleared.
- R7: With `op_sel`=3'd5 and breg_in zero, overflow is set, carry is cleared, and `acc_res`/`b_res` take acc_in/breg_in unchanged.
- R8: Multiply and divide clear auxiliary carry. With `op_sel` at 3'd0, 3'd6 or 3'd7 and no write, the results and all stored status bits keep their values.
- R9: With `psw_we`=1 and no arithmetic operation, `status_byte[7:1]` takes `psw_wdata[7:1]` at the next edge.
- R10: A write coinciding with an arithmetic operation loads bits 5, 4, 3 and 1 from `psw_wdata`, while bits 7, 6 and 2 come from the operation.
- R11: `status_byte[0]` equals the XOR of all bits of `acc_in` at all times, and `psw_wdata[0]` has no effect on it.
- R12: `bank_base` equals 8 times the bank field in status bits 4:3 (0x00, 0x08, 0x10, 0x18).
- R13: Status bits 5 and 1 (user flags) change only through a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation select: 0 none, 1 add, 2 add with carry, 3 subtract with borrow, 4 multiply, 5 divide |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand for add/subtract |
| breg_in | input | 8 | Current B register value (multiplier/divisor) |
| psw_we | input | 1 | Status word write enable |
| psw_wdata | input | 8 | Status word write data |
| acc_res | output | 8 | Registered accumulator result |
| b_res | output | 8 | Registered B result |
| status_byte | output | 8 | Status word; bit 0 is live parity |
| bank_base | output | 8 | Working-register bank base address |

## Verification
Results, carry, auxiliary carry, overflow and written status bits change at the first rising edge after the stimulus. The bench therefore drives at a falling edge and compares at the next falling edge. Parity and the bank base derive combinationally from `acc_in` and the stored bank field, so both are due in that same sample. The operation select and write enable are withdrawn shortly after the capturing edge, which lets each sample see exactly one update. The bench's own model of the status word and results carries state, such as the stored carry, from one step to the next.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int SW = 8;

  localparam int BIT_CY = 7;
  localparam int BIT_AC = 6;
  localparam int BIT_U0 = 5;
  localparam int BIT_RSH = 4;
  localparam int BIT_RSL = 3;
  localparam int BIT_OV = 2;
  localparam int BIT_U1 = 1;
  localparam int BIT_PAR = 0;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADDC = 3'd2,
    OP_SUBB = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } op_t;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } aflags_t;

  typedef struct packed {
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    aflags_t       f;
  } ares_t;

  // Addition with carry-in; carry from top bit and from the low nibble.
  function automatic ares_t f_add(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic cin);
    ares_t         r;
    logic [DW:0]   full;
    logic [NW:0]   nib;
    full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    nib  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    r.lo = full[DW-1:0];
    r.hi = '0;
    r.f.cy = full[DW];
    r.f.ac = nib[NW];
    r.f.ov = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
    return r;
  endfunction

  // Subtraction with borrow-in; the wrapped top bit of each difference is the borrow.
  function automatic ares_t f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic bin);
    ares_t         r;
    logic [DW:0]   full;
    logic [NW:0]   nib;
    full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
    nib  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, bin};
    r.lo = full[DW-1:0];
    r.hi = '0;
    r.f.cy = full[DW];
    r.f.ac = nib[NW];
    r.f.ov = (a[DW-1] != b[DW-1]) && (full[DW-1] != a[DW-1]);
    return r;
  endfunction

  function automatic ares_t f_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    ares_t          r;
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    r.lo = p[DW-1:0];
    r.hi = p[2*DW-1:DW];
    r.f.cy = 1'b0;
    r.f.ac = 1'b0;
    r.f.ov = |p[2*DW-1:DW];
    return r;
  endfunction

  // A zero divisor leaves both bytes as they were and raises overflow.
  function automatic ares_t f_div(input logic [DW-1:0] a, input logic [DW-1:0] b);
    ares_t r;
    r.f.cy = 1'b0;
    r.f.ac = 1'b0;
    if (b == '0) begin
      r.lo = a;
      r.hi = b;
      r.f.ov = 1'b1;
    end else begin
      r.lo = a / b;
      r.hi = a % b;
      r.f.ov = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          use_cin,
  input  logic          is_sub,
  output ares_t         res
);

  logic carry_used;
  assign carry_used = use_cin & cin;

  always_comb begin
    if (is_sub) res = f_sub(a, b, carry_used);
    else        res = f_add(a, b, carry_used);
  end

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          is_div,
  output ares_t         res,
  output logic          div_zero
);

  ares_t mul_r;
  ares_t div_r;

  assign mul_r    = f_mul(a, b);
  assign div_r    = f_div(a, b);
  assign div_zero = is_div && (b == '0);
  assign res      = is_div ? div_r : mul_r;

endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  aflags_t       flg,
  input  logic          we,
  input  logic [SW-1:0] wdata,
  input  logic [DW-1:0] acc_now,
  output logic [SW-1:0] status,
  output logic [1:0]    bank_sel
);

  logic [SW-1:1] held;
  logic [SW-1:1] nxt;
  logic          unused_wbit;

  assign unused_wbit = wdata[BIT_PAR];

  always_comb begin
    nxt = held;
    if (we) nxt = wdata[SW-1:1];
    if (upd) begin
      nxt[BIT_CY] = flg.cy;
      nxt[BIT_AC] = flg.ac;
      nxt[BIT_OV] = flg.ov;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= nxt;
  end

  assign status   = {held, ^acc_now};
  assign bank_sel = held[BIT_RSH:BIT_RSL];

  a_r9_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !upd) |=> (status[SW-1:1] == $past(wdata[SW-1:1])));

  a_r10_arith_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && upd) |=> (status[BIT_CY] == $past(flg.cy) && status[BIT_OV] == $past(flg.ov)
                     && status[BIT_U0] == $past(wdata[BIT_U0])
                     && status[BIT_RSH:BIT_RSL] == $past(wdata[BIT_RSH:BIT_RSL])));

  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !upd) |=> $stable(status[SW-1:1]));

  a_r13_user_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> ($stable(status[BIT_U0]) && $stable(status[BIT_U1])));

endmodule

// File: rtl/alu8_bank_decode.sv
module alu8_bank_decode #(
  parameter int BANK_REGS = 8,
  parameter int AW        = 8
) (
  input  logic [1:0]    bank_sel,
  output logic [AW-1:0] base
);

  localparam int SHIFT = $clog2(BANK_REGS);

  generate
    if (SHIFT + 2 <= AW) begin : g_fit
      assign base = AW'({bank_sel, {SHIFT{1'b0}}});
    end else begin : g_clip
      logic [SHIFT+1:0] wide;
      assign wide = {bank_sel, {SHIFT{1'b0}}};
      assign base = wide[AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int BANK_REGS = 8,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_sel,
  input  logic [7:0]    acc_in,
  input  logic [7:0]    opnd_in,
  input  logic [7:0]    breg_in,
  input  logic          psw_we,
  input  logic [7:0]    psw_wdata,
  output logic [7:0]    acc_res,
  output logic [7:0]    b_res,
  output logic [7:0]    status_byte,
  output logic [AW-1:0] bank_base
);

  op_t     op;
  logic    ev_addsub;
  logic    ev_muldiv;
  logic    ev_arith;
  logic    ev_div0;
  logic    ev_mul_big;
  ares_t   as_r;
  ares_t   md_r;
  ares_t   sel_r;
  logic [1:0] bank_sel;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] b_q;

  assign op        = op_t'(op_sel);
  assign ev_addsub = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
  assign ev_muldiv = (op == OP_MUL) || (op == OP_DIV);
  assign ev_arith  = ev_addsub || ev_muldiv;

  alu8_addsub u_addsub (
    .a       (acc_in),
    .b       (opnd_in),
    .cin     (status_byte[BIT_CY]),
    .use_cin (op != OP_ADD),
    .is_sub  (op == OP_SUBB),
    .res     (as_r)
  );

  alu8_muldiv u_muldiv (
    .a        (acc_in),
    .b        (breg_in),
    .is_div   (op == OP_DIV),
    .res      (md_r),
    .div_zero (ev_div0)
  );

  assign ev_mul_big = (op == OP_MUL) && md_r.f.ov;
  assign sel_r      = ev_muldiv ? md_r : as_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b_q   <= '0;
    end else if (ev_arith) begin
      acc_q <= sel_r.lo;
      if (ev_muldiv) b_q <= sel_r.hi;
    end
  end

  assign acc_res = acc_q;
  assign b_res   = b_q;

  alu8_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (ev_arith),
    .flg      (sel_r.f),
    .we       (psw_we),
    .wdata    (psw_wdata),
    .acc_now  (acc_in),
    .status   (status_byte),
    .bank_sel (bank_sel)
  );

  alu8_bank_decode #(.BANK_REGS(BANK_REGS), .AW(AW)) u_bank (
    .bank_sel (bank_sel),
    .base     (bank_base)
  );

  a_r5_mul_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MUL) |=> (status_byte[BIT_OV] == (b_res != 8'h00) && !status_byte[BIT_CY]));

  a_r6_div_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIV && breg_in != 8'h00) |=> (!status_byte[BIT_OV] && !status_byte[BIT_CY]
                                            && b_res < $past(breg_in)));

  a_r7_div0_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ev_div0 |=> (acc_res == $past(acc_in) && b_res == $past(breg_in)
                 && status_byte[BIT_OV] && !status_byte[BIT_CY]));

  a_r8_muldiv_ac: assert property (@(posedge clk) disable iff (!rst_n)
    ev_muldiv |=> !status_byte[BIT_AC]);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_arith |=> ($stable(acc_res) && $stable(b_res)));

  a_r12_bank_base: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_base[2:0] == 3'b000 && bank_base[4:3] == status_byte[BIT_RSH:BIT_RSL]));

  a_r5_mul_big_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mul_big |=> status_byte[BIT_OV]);

endmodule

// File: tb/alu8_status_unit_bench.sv
module alu8_status_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] opnd_in = 8'h00;
  logic [7:0] breg_in = 8'h00;
  logic       psw_we = 1'b0;
  logic [7:0] psw_wdata = 8'h00;
  logic [7:0] acc_res;
  logic [7:0] b_res;
  logic [7:0] status_byte;
  logic [7:0] bank_base;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_acc = 8'h00;
  logic [7:0] m_b   = 8'h00;
  logic [7:0] m_psw = 8'h00; // bit 0 unused; parity computed at check time

  always #5 clk = ~clk;

  alu8_status_unit u_alu8_status_unit (
    .clk (clk), .rst_n (rst_n), .op_sel (op_sel), .acc_in (acc_in),
    .opnd_in (opnd_in), .breg_in (breg_in), .psw_we (psw_we),
    .psw_wdata (psw_wdata), .acc_res (acc_res), .b_res (b_res),
    .status_byte (status_byte), .bank_base (bank_base)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int par8(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c % 2;
  endfunction

  task automatic compare_all(input string tag);
    int exp_st;
    exp_st = (int'(m_psw) & 'hFE) | par8(int'(acc_in));
    chk(tag, "acc_res", int'(acc_res), int'(m_acc));
    chk(tag, "b_res", int'(b_res), int'(m_b));
    chk(tag, "status_byte", int'(status_byte), exp_st);
    chk(tag, "bank_base", int'(bank_base), ((exp_st >> 3) & 3) * 8);
  endtask

  // Drive one cycle of stimulus, advance the model, and compare after the edge.
  task automatic step(input string tag, input int op, input int a, input int o,
                      input int b, input bit we, input int wd);
    int cy, ac, ov, r, t, hi;
    bit arith;
    @(negedge clk);
    op_sel = 3'(op); acc_in = 8'(a); opnd_in = 8'(o); breg_in = 8'(b);
    psw_we = we; psw_wdata = 8'(wd);
    cy = int'(m_psw[7]); ac = 0; ov = 0; r = int'(m_acc); hi = int'(m_b);
    arith = 1'b1;
    case (op)
      1, 2: begin
        int ci;
        ci = (op == 2) ? cy : 0;
        t  = a + o + ci;
        r  = t % 256;
        cy = (t > 255) ? 1 : 0;
        ac = (((a % 16) + (o % 16) + ci) > 15) ? 1 : 0;
        t  = sx(a) + sx(o) + ci;
        ov = (t > 127 || t < -128) ? 1 : 0;
      end
      3: begin
        int bi;
        bi = cy;
        t  = a - o - bi;
        r  = (t + 256) % 256;
        cy = (t < 0) ? 1 : 0;
        ac = (((a % 16) - (o % 16) - bi) < 0) ? 1 : 0;
        t  = sx(a) - sx(o) - bi;
        ov = (t > 127 || t < -128) ? 1 : 0;
      end
      4: begin
        t = a * b; r = t % 256; hi = t / 256; cy = 0; ov = (t > 255) ? 1 : 0;
      end
      5: begin
        cy = 0;
        if (b == 0) begin r = a; hi = b; ov = 1; end
        else begin r = a / b; hi = a % b; ov = 0; end
      end
      default: arith = 1'b0;
    endcase
    if (we) m_psw = 8'(wd) & 8'hFE;
    if (arith) begin
      m_acc = 8'(r); m_b = 8'(hi);
      m_psw[7] = cy[0]; m_psw[6] = ac[0]; m_psw[2] = ov[0];
    end
    @(posedge clk);
    #2;
    op_sel = 3'd0; psw_we = 1'b0;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic t_reset();
    chk("R1", "acc_res", int'(acc_res), 0);
    chk("R1", "b_res", int'(b_res), 0);
    chk("R1", "status_byte", int'(status_byte), 0);
    chk("R1", "bank_base", int'(bank_base), 0);
  endtask

  task automatic t_add();
    step("R2", 1, 'h7F, 'h01, 0, 0, 0);
    step("R2", 1, 'hFF, 'h01, 0, 0, 0);
    step("R2", 1, 'h12, 'h34, 0, 0, 0);
    step("R2", 1, 'h80, 'h80, 0, 0, 0);
  endtask

  task automatic t_addc();
    step("R3", 1, 'hF0, 'h20, 0, 0, 0);
    step("R3", 2, 'h10, 'h20, 0, 0, 0);
    step("R3", 2, 'h3F, 'h40, 0, 0, 0);
  endtask

  task automatic t_subb();
    step("R4", 3, 'h00, 'h01, 0, 0, 0);
    step("R4", 3, 'h50, 'h10, 0, 0, 0);
    step("R4", 3, 'h80, 'h01, 0, 0, 0);
    step("R4", 3, 'h7F, 'hFF, 0, 0, 0);
  endtask

  task automatic t_mul();
    step("R5", 4, 'h10, 0, 'h10, 0, 0);
    step("R5", 4, 'h0C, 0, 'h0A, 0, 0);
    step("R5", 4, 'hFF, 0, 'hFF, 0, 0);
  endtask

  task automatic t_div();
    step("R6", 5, 'hFB, 0, 'h12, 0, 0);
    step("R6", 5, 'h07, 0, 'h09, 0, 0);
  endtask

  task automatic t_div0();
    step("R3", 1, 'hFF, 'h01, 0, 0, 0);
    step("R7", 5, 'h55, 0, 'h00, 0, 0);
  endtask

  task automatic t_quiet();
    step("R2", 1, 'h08, 'h08, 0, 0, 0);
    step("R8", 4, 'h0F, 0, 'h01, 0, 0);
    step("R2", 1, 'h88, 'h88, 0, 0, 0);
    step("R8", 0, 'h33, 'h44, 'h55, 0, 0);
    step("R8", 6, 'h33, 'h44, 'h55, 0, 0);
    step("R8", 7, 'h01, 'h02, 'h03, 0, 0);
  endtask

  task automatic t_write();
    step("R9", 0, 'h01, 0, 0, 1, 'hFF);
    step("R9", 0, 'h01, 0, 0, 1, 'h24);
  endtask

  task automatic t_collide();
    step("R10", 1, 'hFF, 'h01, 0, 1, 'h3A);
    step("R10", 3, 'h10, 'h20, 0, 1, 'hC4);
  endtask

  task automatic t_parity();
    step("R11", 0, 'h00, 0, 0, 1, 'h01);
    step("R11", 0, 'h07, 0, 0, 0, 0);
    step("R11", 0, 'hA5, 0, 0, 0, 0);
    @(negedge clk);
    acc_in = 8'h80;
    #1;
    chk("R11", "parity bit", int'(status_byte[0]), 1);
  endtask

  task automatic t_bank();
    for (int k = 0; k < 4; k++) begin
      step("R12", 0, 'h00, 0, 0, 1, k * 8);
      chk("R12", "bank_base direct", int'(bank_base), k * 8);
    end
  endtask

  task automatic t_user();
    step("R13", 0, 'h00, 0, 0, 1, 'h22);
    step("R13", 1, 'h40, 'h40, 0, 0, 0);
    step("R13", 5, 'h09, 0, 'h00, 0, 0);
    chk("R13", "user flags", int'({status_byte[5], status_byte[1]}), 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_addc();
    t_subb();
    t_mul();
    t_div();
    t_div0();
    t_quiet();
    t_write();
    t_collide();
    t_parity();
    t_bank();
    t_user();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule